// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This unit sits on the processor side of the interrupt path. It decides when an incoming request may interrupt the program, and it then performs the interrupt entry steps. Each clock it looks at one maskable request, which carries a level and a vector number, and at a non-maskable pulse. A request can only be taken in a cycle where the current instruction completes. On entry it writes the return address and then the status word to a downward-growing stack. It then clears the status enable bit, raises the status level to the accepted level (a non-maskable entry keeps the old level) and jumps to the handler. The handler address is the vector base plus four times the vector number.

A return command reverses the entry. The unit reads the status word and then the return address back from the stack, and restores both. Software may rewrite the status word between instructions. Setting the enable bit inside a handler permits nesting, but only for requests whose level is above the level now held. The maskable request and the memory request port use valid/ready handshakes. A request holds valid and its payload until ready is seen. The memory request holds valid, address, write flag and data until the memory raises ready. A read response arrives in any cycle after the read handshake. All other pins are plain strobes or levels.

Top module: `irq_seq`

## Requirements
- R1: After reset the program counter equals RESET_PC, the status enable bit and level are 0, the stack pointer equals SP_INIT, busy is low and no memory request is valid.
- R2: irq_ready is high only in a cycle where the unit is idle, insn_done is high, reti_cmd is low, no non-maskable request is pending or arriving, irq_valid is high, the status enable bit is 1 and irq_level is strictly greater than the status level. Requests are evaluated every cycle, and one that fails these tests stays unaccepted without being lost.
- R3: A nmi_req pulse seen while idle is remembered until it is taken. It is taken at the next idle cycle with insn_done high whatever the enable bit and level, and it wins over a maskable request in the same cycle.
- R4: Entry makes two writes in order. First the return address (insn_next_pc of the accepting cycle) goes to SP−2. Then the status word as it was before entry goes to SP−4. The status word has enable in bit 0 and level in bits 3:1. The stack pointer falls by 2 at each write handshake.
- R5: In the cycle after the second write handshake of a maskable entry, the enable bit is 0, the level equals the accepted irq_level and the program counter equals vec_base + 4·irq_vecnum.
- R6: A non-maskable entry leaves the level unchanged and jumps to vec_base + 4·NMI_VEC.
- R7: busy is high from the cycle after acceptance through the last handshake or response of an entry or return. While busy, irq_ready stays low, and nmi_req, insn_done and psr_wr_en have no effect.
- R8: reti_cmd while idle reads the status word at SP, then the return address at SP+2. The stack pointer rises by 2 per response. When the second response arrives, the status word and the program counter are restored. reti_cmd takes precedence over acceptance in the same cycle.
- R9: psr_wr_en in an idle cycle with no acceptance and no return loads enable from psr_wr_data bit 0 and level from bits 3:1 on the next edge. It is ignored in an accepting cycle.
- R10: In an idle cycle with insn_done high and no acceptance or return, the program counter takes insn_next_pc.
- R11: While mem_req_valid is high and mem_req_ready is low, the request and its address, write flag and data stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | Current instruction completes this cycle |
| insn_next_pc | input | W | Address of the following instruction |
| irq_valid | input | 1 | Maskable request valid |
| irq_ready | output | 1 | Maskable request accepted |
| irq_level | input | LVL_W | Level of the maskable request |
| irq_vecnum | input | VN_W | Vector number of the maskable request |
| nmi_req | input | 1 | Non-maskable request pulse |
| reti_cmd | input | 1 | Return-from-interrupt command |
| vec_base | input | W | Vector table base address |
| psr_wr_en | input | 1 | Software write of the status word |
| psr_wr_data | input | W | Status word to write |
| mem_req_valid | output | 1 | Stack memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a write |
| mem_addr | output | W | Byte address of the request |
| mem_wdata | output | W | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | W | Read data |
| pc | output | W | Program counter |
| psr_ie | output | 1 | Status enable bit |
| psr_il | output | LVL_W | Status level field |
| sp | output | W | Stack pointer |
| busy | output | 1 | Entry or return in progress |

## Verification
Requests are offered in several situations: with the enable bit clear, at a level equal to the current level, and above it. This shows whether the enable gate and the strict level comparison are separate checks. A non-maskable pulse is raised one cycle before a maskable request that completes in the same cycle as its instruction. This shows both the remembered pulse and its precedence, and the level is then compared to prove it was left alone. Two nested entries unwound by returns, with a stalling memory and varying read latency, show that the stack order holds and that handshakes wait. A return in the same cycle as an eligible request shows which of the two wins.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_PSR,
    ST_POP_PSR_RQ,
    ST_POP_PSR_WT,
    ST_POP_PC_RQ,
    ST_POP_PC_WT
  } seq_state_e;
endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb #(
  parameter int LVL_W = 3
) (
  input  logic             idle,
  input  logic             insn_done,
  input  logic             reti_cmd,
  input  logic             nmi_pend,
  input  logic             irq_valid,
  input  logic [LVL_W-1:0] irq_level,
  input  logic             ie,
  input  logic [LVL_W-1:0] il,
  output logic             take_nmi,
  output logic             take_irq
);
  logic can_enter;
  logic lvl_above;

  always_comb begin
    can_enter = idle && insn_done && !reti_cmd;
    lvl_above = irq_level > il;
    take_nmi  = can_enter && nmi_pend;
    take_irq  = can_enter && !nmi_pend && irq_valid && ie && lvl_above;
  end
endmodule

// File: rtl/irq_seq_vec.sv
module irq_seq_vec #(
  parameter int W    = 16,
  parameter int VN_W = 5
) (
  input  logic [W-1:0]    base,
  input  logic [VN_W-1:0] vecnum,
  output logic [W-1:0]    vaddr
);
  localparam int OFS_W = VN_W + 2;
  logic [OFS_W-1:0] ofs;

  always_comb begin
    ofs   = {vecnum, 2'b00};
    vaddr = base + W'(ofs);
  end
endmodule

// File: rtl/irq_seq_sp.sv
module irq_seq_sp #(
  parameter int          W       = 16,
  parameter int          STEP    = 2,
  parameter logic [W-1:0] SP_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec,
  input  logic         inc,
  output logic [W-1:0] sp_q,
  output logic [W-1:0] sp_dn
);
  always_comb sp_dn = sp_q - W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp_q <= SP_INIT;
    else if (dec) sp_q <= sp_dn;
    else if (inc) sp_q <= sp_q + W'(STEP);
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int           W        = 16,
  parameter int           LVL_W    = 3,
  parameter int           VN_W     = 5,
  parameter int           NMI_VEC  = 1,
  parameter logic [W-1:0] RESET_PC = 16'h0100,
  parameter logic [W-1:0] SP_INIT  = 16'h0800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_done,
  input  logic [W-1:0]     insn_next_pc,
  input  logic             irq_valid,
  output logic             irq_ready,
  input  logic [LVL_W-1:0] irq_level,
  input  logic [VN_W-1:0]  irq_vecnum,
  input  logic             nmi_req,
  input  logic             reti_cmd,
  input  logic [W-1:0]     vec_base,
  input  logic             psr_wr_en,
  input  logic [W-1:0]     psr_wr_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic             mem_rsp_valid,
  input  logic [W-1:0]     mem_rsp_data,
  output logic [W-1:0]     pc,
  output logic             psr_ie,
  output logic [LVL_W-1:0] psr_il,
  output logic [W-1:0]     sp,
  output logic             busy
);
  localparam int STEP = W / 8;

  seq_state_e       st_q;
  logic [W-1:0]     pc_q;
  logic             ie_q;
  logic [LVL_W-1:0] il_q;
  logic             nmi_pend_q;
  logic             ent_nmi_q;
  logic [LVL_W-1:0] ent_lvl_q;
  logic [VN_W-1:0]  ent_vec_q;
  logic [W-1:0]     pop_psr_q;

  logic             idle;
  logic             nmi_now;
  logic             take_nmi;
  logic             take_irq;
  logic             req_hs;
  logic             rsp_take;
  logic             sp_dec;
  logic             sp_inc;
  logic [W-1:0]     sp_q;
  logic [W-1:0]     sp_dn;
  logic [W-1:0]     vec_addr;
  logic [W-1:0]     psr_word;

  always_comb begin
    idle     = (st_q == ST_IDLE);
    nmi_now  = nmi_pend_q || nmi_req;
    psr_word = W'({il_q, ie_q});
  end

  irq_seq_arb #(.LVL_W(LVL_W)) arb_i (
    .idle      (idle),
    .insn_done (insn_done),
    .reti_cmd  (reti_cmd),
    .nmi_pend  (nmi_now),
    .irq_valid (irq_valid),
    .irq_level (irq_level),
    .ie        (ie_q),
    .il        (il_q),
    .take_nmi  (take_nmi),
    .take_irq  (take_irq)
  );

  irq_seq_vec #(.W(W), .VN_W(VN_W)) vec_i (
    .base   (vec_base),
    .vecnum (ent_vec_q),
    .vaddr  (vec_addr)
  );

  irq_seq_sp #(.W(W), .STEP(STEP), .SP_INIT(SP_INIT)) sp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .dec   (sp_dec),
    .inc   (sp_inc),
    .sp_q  (sp_q),
    .sp_dn (sp_dn)
  );

  // stack port drive per state
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_addr      = sp_q;
    mem_wdata     = '0;
    unique case (st_q)
      ST_PUSH_PC: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_addr      = sp_dn;
        mem_wdata     = pc_q;
      end
      ST_PUSH_PSR: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_addr      = sp_dn;
        mem_wdata     = psr_word;
      end
      ST_POP_PSR_RQ, ST_POP_PC_RQ: begin
        mem_req_valid = 1'b1;
      end
      default: ;
    endcase
    req_hs   = mem_req_valid && mem_req_ready;
    rsp_take = mem_rsp_valid && (st_q == ST_POP_PSR_WT || st_q == ST_POP_PC_WT);
    sp_dec   = req_hs && mem_req_we;
    sp_inc   = rsp_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pc_q       <= RESET_PC;
      ie_q       <= 1'b0;
      il_q       <= '0;
      nmi_pend_q <= 1'b0;
      ent_nmi_q  <= 1'b0;
      ent_lvl_q  <= '0;
      ent_vec_q  <= '0;
      pop_psr_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          nmi_pend_q <= take_nmi ? 1'b0 : nmi_now;
          if (reti_cmd) begin
            st_q <= ST_POP_PSR_RQ;
          end else if (take_nmi || take_irq) begin
            st_q      <= ST_PUSH_PC;
            pc_q      <= insn_next_pc;
            ent_nmi_q <= take_nmi;
            ent_lvl_q <= irq_level;
            ent_vec_q <= take_nmi ? VN_W'(NMI_VEC) : irq_vecnum;
          end else begin
            if (insn_done) pc_q <= insn_next_pc;
            if (psr_wr_en) begin
              ie_q <= psr_wr_data[0];
              il_q <= psr_wr_data[LVL_W:1];
            end
          end
        end
        ST_PUSH_PC: begin
          if (req_hs) st_q <= ST_PUSH_PSR;
        end
        ST_PUSH_PSR: begin
          if (req_hs) begin
            st_q <= ST_IDLE;
            ie_q <= 1'b0;
            if (!ent_nmi_q) il_q <= ent_lvl_q;
            pc_q <= vec_addr;
          end
        end
        ST_POP_PSR_RQ: begin
          if (req_hs) st_q <= ST_POP_PSR_WT;
        end
        ST_POP_PSR_WT: begin
          if (rsp_take) begin
            pop_psr_q <= mem_rsp_data;
            st_q      <= ST_POP_PC_RQ;
          end
        end
        ST_POP_PC_RQ: begin
          if (req_hs) st_q <= ST_POP_PC_WT;
        end
        ST_POP_PC_WT: begin
          if (rsp_take) begin
            pc_q <= mem_rsp_data;
            ie_q <= pop_psr_q[0];
            il_q <= pop_psr_q[LVL_W:1];
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    irq_ready = take_irq;
    pc        = pc_q;
    psr_ie    = ie_q;
    psr_il    = il_q;
    sp        = sp_q;
    busy      = !idle;
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int W     = 16,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_done,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_we,
  input logic [W-1:0]     mem_addr,
  input logic [W-1:0]     mem_wdata,
  input logic             psr_ie,
  input logic [W-1:0]     sp,
  input logic             busy
);
  localparam int STEP = W / 8;

  AST_READY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready |-> (insn_done && irq_valid && psr_ie)); // R2

  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_ready); // R7

  AST_ACCEPT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready |=> busy); // R7

  AST_PUSH_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_we) |=> (sp == $past(sp) - W'(STEP))); // R4

  AST_ENTRY_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(mem_req_we)) |-> !psr_ie); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_req_we))); // R11
endmodule

bind irq_seq irq_seq_chk #(.W(W), .LVL_W(LVL_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_done     (insn_done),
  .irq_valid     (irq_valid),
  .irq_ready     (irq_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .psr_ie        (psr_ie),
  .sp            (sp),
  .busy          (busy)
);

// File: tb/irq_seq_tb_top.sv
`timescale 1ns/1ps
module irq_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_done = 1'b0;
  logic [15:0] insn_next_pc = '0;
  logic        irq_valid = 1'b0;
  logic        irq_ready;
  logic [2:0]  irq_level = '0;
  logic [4:0]  irq_vecnum = '0;
  logic        nmi_req = 1'b0;
  logic        reti_cmd = 1'b0;
  logic [15:0] vec_base = 16'h2000;
  logic        psr_wr_en = 1'b0;
  logic [15:0] psr_wr_data = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        mem_req_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic [15:0] pc;
  logic        psr_ie;
  logic [2:0]  psr_il;
  logic [15:0] sp;
  logic        busy;

  always #2 clk = ~clk;

  irq_seq dut_i (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  int          m_st;
  logic [15:0] m_pc, m_sp, m_pop;
  logic        m_ie, m_np, m_en;
  logic [2:0]  m_il, m_lvl;
  logic [4:0]  m_vec;
  logic [15:0] stk [int];
  bit          rd_pend;
  int          rd_cnt;
  int          rd_addr;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_stk(int a);
    return stk.exists(a) ? stk[a] : 16'h0;
  endfunction

  task automatic tick();
    bit can, npn, t_nmi, t_irq, e_valid, e_we, hs;
    logic [15:0] e_addr, e_wdata;
    #1;
    can     = (m_st == 0) && insn_done && !reti_cmd;
    npn     = m_np || nmi_req;
    t_nmi   = can && npn;
    t_irq   = can && !npn && irq_valid && m_ie && (irq_level > m_il);
    e_valid = (m_st >= 1 && m_st <= 3) || m_st == 5;
    e_we    = (m_st == 1 || m_st == 2);
    e_addr  = e_we ? m_sp - 16'd2 : m_sp;
    e_wdata = (m_st == 1) ? m_pc : {12'h0, m_il, m_ie};
    chk("R10", "pc", 32'(pc), 32'(m_pc));
    chk("R9", "psr_ie", 32'(psr_ie), 32'(m_ie));
    chk("R9", "psr_il", 32'(psr_il), 32'(m_il));
    chk("R4", "sp", 32'(sp), 32'(m_sp));
    chk("R7", "busy", 32'(busy), 32'(m_st != 0));
    chk("R2", "irq_ready", 32'(irq_ready), 32'(t_irq));
    chk("R11", "mem_req_valid", 32'(mem_req_valid), 32'(e_valid));
    if (e_valid) begin
      chk("R11", "mem_req_we", 32'(mem_req_we), 32'(e_we));
      chk("R4", "mem_addr", 32'(mem_addr), 32'(e_addr));
      if (e_we) chk("R4", "mem_wdata", 32'(mem_wdata), 32'(e_wdata));
    end
    hs = e_valid && mem_req_ready;
    case (m_st)
      0: begin
        if (reti_cmd) m_st = 3;
        else if (t_nmi || t_irq) begin
          m_st = 1; m_pc = insn_next_pc; m_en = t_nmi; m_lvl = irq_level;
          m_vec = t_nmi ? 5'd1 : irq_vecnum;
        end else begin
          if (insn_done) m_pc = insn_next_pc;
          if (psr_wr_en) begin m_ie = psr_wr_data[0]; m_il = psr_wr_data[3:1]; end
        end
        m_np = t_nmi ? 1'b0 : npn;
      end
      1, 2: if (hs) begin
        stk[int'(e_addr)] = mem_wdata;
        m_sp = m_sp - 16'd2;
        if (m_st == 2) begin
          m_ie = 1'b0;
          if (!m_en) m_il = m_lvl;
          m_pc = vec_base + 16'(m_vec) * 16'd4;
          m_st = 0;
        end else m_st = 2;
      end
      3, 5: if (hs) begin
        rd_pend = 1'b1; rd_addr = int'(m_sp); rd_cnt = cyc % 3; m_st = m_st + 1;
      end
      4: if (mem_rsp_valid) begin m_pop = mem_rsp_data; m_sp = m_sp + 16'd2; m_st = 5; end
      6: if (mem_rsp_valid) begin
        m_pc = mem_rsp_data; m_ie = m_pop[0]; m_il = m_pop[3:1]; m_sp = m_sp + 16'd2; m_st = 0;
      end
      default: ;
    endcase
    @(negedge clk);
    cyc++;
    if (t_irq) irq_valid = 1'b0;
    mem_req_ready = (cyc % 3) != 1;
    mem_rsp_valid = 1'b0;
    if (rd_pend) begin
      if (rd_cnt == 0) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = rd_stk(rd_addr); rd_pend = 1'b0;
      end else rd_cnt--;
    end
  endtask

  task automatic insn(logic [15:0] npc);
    insn_done = 1'b1; insn_next_pc = npc;
    tick();
    insn_done = 1'b0;
  endtask

  task automatic psr_write(logic [15:0] d);
    psr_wr_en = 1'b1; psr_wr_data = d;
    tick();
    psr_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    tick();
    for (int i = 0; i < 50 && m_st != 0; i++) tick();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_st = 0; m_pc = 16'h0100; m_sp = 16'h0800; m_ie = 0; m_il = 0;
    m_np = 0; m_en = 0; m_lvl = 0; m_vec = 0; m_pop = 0; rd_pend = 0; rd_cnt = 0; rd_addr = 0;
    #1;
    chk("R1", "reset pc", 32'(pc), 32'h0100);
    chk("R1", "reset sp", 32'(sp), 32'h0800);
    chk("R1", "reset status", 32'({psr_il, psr_ie}), 32'h0);
    chk("R1", "reset busy/req", 32'({busy, mem_req_valid}), 32'h0);
    @(negedge clk);

    // R10 plain stepping, R2 request refused while enable is clear
    insn(16'h0102);
    irq_valid = 1'b1; irq_level = 3'd4; irq_vecnum = 5'd6;
    insn(16'h0104);
    tick();
    chk("R2", "no entry with enable clear", 32'(busy), 32'h0);
    irq_valid = 1'b0;

    // R9 status write, equal level refused, higher level taken
    psr_write(16'h0005);
    irq_valid = 1'b1; irq_level = 3'd2; irq_vecnum = 5'd7;
    insn(16'h0110);
    tick();
    chk("R2", "equal level refused", 32'(busy), 32'h0);
    irq_valid = 1'b0;
    irq_valid = 1'b1; irq_level = 3'd3; irq_vecnum = 5'd5;
    insn(16'h0120);
    nmi_req = 1'b1; psr_wr_en = 1'b1; psr_wr_data = 16'h0; insn_done = 1'b1; insn_next_pc = 16'h0999;
    tick();
    nmi_req = 1'b0; psr_wr_en = 1'b0; insn_done = 1'b0;
    wait_idle();
    chk("R5", "vector pc", 32'(pc), 32'h2014);
    chk("R5", "level after entry", 32'(psr_il), 32'd3);
    chk("R5", "enable after entry", 32'(psr_ie), 32'd0);
    chk("R4", "stacked pc", 32'(rd_stk(16'h07FE)), 32'h0120);
    chk("R4", "stacked status", 32'(rd_stk(16'h07FC)), 32'h0005);
    insn(16'h2016);
    tick();
    chk("R7", "nmi pulse while busy dropped", 32'({busy, pc}), 32'h2016);

    // R9 nesting: enable in handler, equal level refused, higher taken
    psr_write(16'h0007);
    irq_valid = 1'b1; irq_level = 3'd3; irq_vecnum = 5'd8;
    insn(16'h2018);
    irq_valid = 1'b0;
    chk("R9", "same level does not nest", 32'(busy), 32'h0);
    irq_valid = 1'b1; irq_level = 3'd5; irq_vecnum = 5'd9;
    insn(16'h201A);
    wait_idle();
    chk("R9", "nested vector", 32'(pc), 32'h2024);
    chk("R5", "nested level", 32'(psr_il), 32'd5);
    chk("R4", "nested sp", 32'(sp), 32'h07F8);

    // R3 remembered pulse wins over simultaneous maskable, R6 level kept
    psr_write(16'h000B);
    nmi_req = 1'b1;
    tick();
    nmi_req = 1'b0;
    irq_valid = 1'b1; irq_level = 3'd7; irq_vecnum = 5'd3;
    insn(16'h2030);
    irq_valid = 1'b0;
    wait_idle();
    chk("R3", "nmi vector", 32'(pc), 32'h2004);
    chk("R6", "nmi keeps level", 32'(psr_il), 32'd5);
    chk("R3", "stacked pc nmi", 32'(rd_stk(16'h07F6)), 32'h2030);

    // R8 returns
    reti_cmd = 1'b1;
    tick();
    reti_cmd = 1'b0;
    wait_idle();
    chk("R8", "return pc", 32'(pc), 32'h2030);
    chk("R8", "return status", 32'({psr_il, psr_ie}), 32'h0B);
    irq_valid = 1'b1; irq_level = 3'd6; irq_vecnum = 5'd2;
    reti_cmd = 1'b1; insn_done = 1'b1; insn_next_pc = 16'h2032;
    tick();
    reti_cmd = 1'b0; insn_done = 1'b0; irq_valid = 1'b0;
    wait_idle();
    chk("R8", "return wins over request", 32'(pc), 32'h201A);
    chk("R8", "second return status", 32'({psr_il, psr_ie}), 32'h07);
    reti_cmd = 1'b1;
    tick();
    reti_cmd = 1'b0;
    wait_idle();
    chk("R8", "outer return pc", 32'(pc), 32'h0120);
    chk("R8", "outer return sp", 32'(sp), 32'h0800);
    chk("R8", "outer return status", 32'({psr_il, psr_ie}), 32'h05);
    repeat (4) tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule